// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital control core of a 32-step digitally controlled potentiometer. Three control lines come in from outside: an active-low select, a step strobe and a direction line. All three are sampled into the system clock domain through a two-flop synchronizer. While the block is selected, each falling edge of the strobe moves a 5-bit wiper position one step. The step goes toward the high end or the low end, as the direction line says. At the ends the position saturates.

When select goes high, the block returns to standby. The level of the strobe line at that moment decides whether the current position is committed to a store register that models non-volatile memory. The same pins therefore give both a saving deselect and a plain one. A commit holds a busy output for a fixed, parameterizable number of cycles, and step edges are ignored for that time. A reset reloads the wiper from the store register. A separate power-on input initializes both the wiper and the store to mid-scale. The wiper code is also decoded into a one-hot tap-select vector.

Top module: `wiper_ctrl`

## Requirements
- R1: While `porN` is low, both the wiper and the store register are set to mid-scale, which is code 16 when TAPS is 32. Code 0 is the low terminal and code 31 is the high terminal.
- R2: A falling edge on `stepStrobe` while `selN` is low and `dirUp` is high raises `wiperCode` by one.
- R3: A falling edge on `stepStrobe` while `selN` is low and `dirUp` is low lowers `wiperCode` by one.
- R4: Steps saturate. A step up at code 31 and a step down at code 0 leave the code unchanged, and the code never wraps.
- R5: A rising edge of `selN` while `stepStrobe` is high copies the current wiper code into the store register, whatever the level of `dirUp`.
- R6: A rising edge of `selN` while `stepStrobe` is low leaves the store register unchanged and does not raise `busy`.
- R7: While `selN` is high, edges on `stepStrobe` and changes on `dirUp` do not change `wiperCode`.
- R8: While `rstN` is low and `porN` is high, the wiper loads the value held in the store register.
- R9: A commit holds `busy` high for exactly STORE_CYCLES clock cycles. `busy` rises on the third clock edge after the select rise is driven. While `busy` is high, strobe edges do not move the wiper.
- R10: `tapSel` always has exactly one bit set, and that bit is the bit whose index equals `wiperCode`.
- R11: A strobe edge driven between clock edges changes `wiperCode` on the third following rising clock edge: two synchronizer flops, then the position register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on initialization, active low, synchronous; sets wiper and store to mid-scale |
| rstN | input | 1 | Reset, active low, synchronous; reloads the wiper from the store register |
| selN | input | 1 | Chip select, active low, asynchronous to `clk` |
| stepStrobe | input | 1 | Step strobe; a falling edge steps the wiper, and its level qualifies a deselect |
| dirUp | input | 1 | Step direction: 1 toward the high terminal, 0 toward the low terminal |
| wiperCode | output | $clog2(TAPS) | Current wiper position |
| tapSel | output | TAPS | One-hot tap select decoded from `wiperCode` |
| busy | output | 1 | High while a commit to the store register is in progress |

## Verification
The bench keeps the default TAPS of 32. That puts both terminals within a few dozen strobes of mid-scale, so saturation at code 31 and at code 0 is reached and then pushed against. STORE_CYCLES is raised to 12, which leaves room to drop select and land a strobe edge well inside the busy window. That makes the ignored step observable. Reset pulses between the commit scenarios bring the content of the store register out on `wiperCode`, so a saving deselect and a non-saving deselect can be told apart.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Single-cycle commands from the control path to the datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic commit;
  } wiperCmd_t;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             syncRst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (syncRst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/wiper_ctl.sv
module wiper_ctl
  import wiper_pkg::*;
#(
  parameter int STORE_CYCLES = 8
) (
  input  logic      clk,
  input  logic      blockRst,
  input  logic      selNSync,
  input  logic      strobeSync,
  input  logic      dirSync,
  output wiperCmd_t cmd,
  output logic      busy
);

  localparam int CNT_W = $clog2(STORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(STORE_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_SAVING} ctlState_t;

  ctlState_t        state;
  logic [CNT_W-1:0] holdCnt;
  logic             selPrev;
  logic             strobePrev;
  logic             strobeFall;
  logic             selRise;

  // Previous-sample registers for edge detection
  always_ff @(posedge clk) begin
    if (blockRst) begin
      selPrev    <= 1'b1;
      strobePrev <= 1'b1;
    end else begin
      selPrev    <= selNSync;
      strobePrev <= strobeSync;
    end
  end

  assign strobeFall = strobePrev & ~strobeSync;
  assign selRise    = ~selPrev & selNSync;
  assign busy       = (state == ST_SAVING);

  always_comb begin
    cmd          = '0;
    cmd.stepUp   = strobeFall & ~selNSync & ~busy & dirSync;
    cmd.stepDown = strobeFall & ~selNSync & ~busy & ~dirSync;
    cmd.commit   = selRise & strobeSync & ~busy;
  end

  // Store timer: busy for exactly STORE_CYCLES cycles per commit
  always_ff @(posedge clk) begin
    if (blockRst) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd.commit) begin
            state   <= ST_SAVING;
            holdCnt <= HOLD_LAST;
          end
        end
        ST_SAVING: begin
          if (holdCnt == '0) state <= ST_IDLE;
          else               holdCnt <= holdCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wiper_dp.sv
module wiper_dp
  import wiper_pkg::*;
#(
  parameter int TAPS      = 32,
  parameter int INIT_CODE = TAPS / 2
) (
  input  logic                    clk,
  input  logic                    porN,
  input  logic                    rstN,
  input  wiperCmd_t               cmd,
  output logic [$clog2(TAPS)-1:0] wiperCode,
  output logic [TAPS-1:0]         tapSel
);

  localparam int CODE_W = $clog2(TAPS);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(TAPS - 1);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(INIT_CODE);

  logic [CODE_W-1:0] posReg;
  logic [CODE_W-1:0] storeReg;

  // Store register stands in for the non-volatile cell
  always_ff @(posedge clk) begin
    if (!porN)           storeReg <= MID_CODE;
    else if (cmd.commit) storeReg <= posReg;
  end

  always_ff @(posedge clk) begin
    if (!porN)                                posReg <= MID_CODE;
    else if (!rstN)                           posReg <= storeReg;
    else if (cmd.stepUp && posReg != TOP_CODE) posReg <= posReg + 1'b1;
    else if (cmd.stepDown && posReg != '0)    posReg <= posReg - 1'b1;
  end

  assign wiperCode = posReg;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapSel[t] = (posReg == CODE_W'(t));
  end

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 8,
  parameter int INIT_CODE    = TAPS / 2
) (
  input  logic                    clk,
  input  logic                    porN,
  input  logic                    rstN,
  input  logic                    selN,
  input  logic                    stepStrobe,
  input  logic                    dirUp,
  output logic [$clog2(TAPS)-1:0] wiperCode,
  output logic [TAPS-1:0]         tapSel,
  output logic                    busy
);

  logic      blockRst;
  logic [2:0] syncOut;
  wiperCmd_t cmd;

  assign blockRst = ~rstN | ~porN;

  // Bit order {select, strobe, direction}; idle levels deselected, strobe high
  wiper_sync #(
    .WIDTH  (3),
    .STAGES (2),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk    (clk),
    .syncRst(blockRst),
    .din    ({selN, stepStrobe, dirUp}),
    .dout   (syncOut)
  );

  wiper_ctl #(
    .STORE_CYCLES(STORE_CYCLES)
  ) u_ctl (
    .clk       (clk),
    .blockRst  (blockRst),
    .selNSync  (syncOut[2]),
    .strobeSync(syncOut[1]),
    .dirSync   (syncOut[0]),
    .cmd       (cmd),
    .busy      (busy)
  );

  wiper_dp #(
    .TAPS     (TAPS),
    .INIT_CODE(INIT_CODE)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .rstN     (rstN),
    .cmd      (cmd),
    .wiperCode(wiperCode),
    .tapSel   (tapSel)
  );

endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 8
) (
  input logic                    clk,
  input logic                    porN,
  input logic                    rstN,
  input logic                    busy,
  input logic [$clog2(TAPS)-1:0] wiperCode,
  input logic [TAPS-1:0]         tapSel
);

  localparam int RUN_W = $clog2(STORE_CYCLES + 2);

  logic [1:0]       warmCnt;
  logic             warm;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN || !porN)        warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 1'b1;
  end
  assign warm = (warmCnt >= 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN || !porN)                      busyRun <= '0;
    else if (busy && busyRun != '1)          busyRun <= busyRun + 1'b1;
    else if (!busy)                          busyRun <= '0;
  end

  a_r10_one_hot: assert property (@(posedge clk) disable iff (!porN)
    $countones(tapSel) == 1);

  a_r10_index_match: assert property (@(posedge clk) disable iff (!porN)
    tapSel[wiperCode] == 1'b1);

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rstN || !porN || !warm)
    (wiperCode == $past(wiperCode)) ||
    ({1'b0, wiperCode} == {1'b0, $past(wiperCode)} + 1'b1) ||
    ({1'b0, $past(wiperCode)} == {1'b0, wiperCode} + 1'b1));

  a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rstN || !porN || !warm)
    $past(busy) |-> $stable(wiperCode));

  a_r9_busy_length: assert property (@(posedge clk) disable iff (!rstN || !porN || !warm)
    $fell(busy) |-> busyRun == RUN_W'(STORE_CYCLES));

  a_r9_busy_max: assert property (@(posedge clk) disable iff (!rstN || !porN)
    busyRun <= RUN_W'(STORE_CYCLES));

endmodule

bind wiper_ctrl wiper_ctrl_chk #(
  .TAPS        (TAPS),
  .STORE_CYCLES(STORE_CYCLES)
) u_chk (
  .clk      (clk),
  .porN     (porN),
  .rstN     (rstN),
  .busy     (busy),
  .wiperCode(wiperCode),
  .tapSel   (tapSel)
);

// File: tb/wiper_ctrl_bench.sv
module wiper_ctrl_bench;

  localparam int TAPS         = 32;
  localparam int STORE_CYCLES = 12;
  localparam int CODE_W       = $clog2(TAPS);

  logic              clk = 1'b0;
  logic              porN, rstN, selN, stepStrobe, dirUp;
  logic [CODE_W-1:0] wiperCode;
  logic [TAPS-1:0]   tapSel;
  logic              busy;

  typedef struct {
    logic [CODE_W-1:0] code;
    logic              busyE;
    string             tag;
  } item_t;

  item_t sbQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  int    model   = 0;

  always #10 clk = ~clk;

  wiper_ctrl #(
    .TAPS        (TAPS),
    .STORE_CYCLES(STORE_CYCLES)
  ) u_wiper_ctrl (
    .clk       (clk),
    .porN      (porN),
    .rstN      (rstN),
    .selN      (selN),
    .stepStrobe(stepStrobe),
    .dirUp     (dirUp),
    .wiperCode (wiperCode),
    .tapSel    (tapSel),
    .busy      (busy)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: push and wait until the monitor consumed it
  task automatic expectOut(input int code, input logic b, input string tag);
    item_t it;
    it.code  = CODE_W'(code);
    it.busyE = b;
    it.tag   = tag;
    sbQ.push_back(it);
    while (sbQ.size() != 0) @(negedge clk);
  endtask

  task automatic step(input logic up);
    dirUp = up;
    stepStrobe = 1'b0;
    idle(4);
    stepStrobe = 1'b1;
    idle(4);
    if (!selN) begin
      if (up && model < TAPS - 1) model++;
      else if (!up && model > 0)  model--;
    end
  endtask

  // Monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbQ.size() > 0) begin
        item_t it;
        logic [TAPS-1:0] expSel;
        it = sbQ.pop_front();
        expSel = TAPS'(1) << it.code;
        nChecks++;
        if (wiperCode !== it.code || busy !== it.busyE) begin
          nFails++;
          $display("FAIL %s: code=%0d busy=%b expected code=%0d busy=%b",
                   it.tag, wiperCode, busy, it.code, it.busyE);
        end
        nChecks++;
        if (tapSel !== expSel) begin
          nFails++;
          $display("FAIL R10 (%s): tapSel=%h expected %h", it.tag, tapSel, expSel);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run actual=hung expected=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    porN = 1'b0; rstN = 1'b0; selN = 1'b1; stepStrobe = 1'b1; dirUp = 1'b0;
    idle(3);
    porN = 1'b1; rstN = 1'b1;
    idle(4);
    model = 16;
    expectOut(16, 1'b0, "R1 power-on mid-scale");

    // R7: standby ignores strobe and direction
    step(1'b1); step(1'b1); step(1'b0); step(1'b1);
    expectOut(16, 1'b0, "R7 standby ignores strobes");

    selN = 1'b0;
    idle(4);
    // R11: latency of three rising edges
    dirUp = 1'b1;
    stepStrobe = 1'b0;
    expectOut(16, 1'b0, "R11 edge 1 unchanged");
    expectOut(16, 1'b0, "R11 edge 2 unchanged");
    expectOut(17, 1'b0, "R11 edge 3 updated");
    stepStrobe = 1'b1;
    idle(4);
    model = 17;
    step(1'b1); step(1'b1);
    expectOut(19, 1'b0, "R2 step up");
    step(1'b0); step(1'b0);
    expectOut(17, 1'b0, "R3 step down");

    // R5 commit with direction low (ignored), R9 busy window
    dirUp = 1'b0;
    selN = 1'b1;
    expectOut(17, 1'b0, "R9 busy not yet (1)");
    expectOut(17, 1'b0, "R9 busy not yet (2)");
    for (int i = 0; i < STORE_CYCLES; i++) expectOut(17, 1'b1, "R9 busy held");
    expectOut(17, 1'b0, "R9 busy released");
    idle(2);

    // R6: deselect with strobe low does not commit
    selN = 1'b0;
    idle(4);
    step(1'b1);
    dirUp = 1'b1;
    stepStrobe = 1'b0;
    idle(4);
    selN = 1'b1;
    idle(4);
    stepStrobe = 1'b1;
    idle(4);
    expectOut(19, 1'b0, "R6 no busy on plain deselect");
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(4);
    model = 17;
    expectOut(17, 1'b0, "R8 R5 R6 reload keeps committed value");

    // R4 saturation at both ends
    selN = 1'b0;
    idle(4);
    repeat (16) step(1'b1);
    expectOut(31, 1'b0, "R4 reach top");
    step(1'b1);
    expectOut(31, 1'b0, "R4 saturate top");
    repeat (31) step(1'b0);
    expectOut(0, 1'b0, "R4 reach bottom");
    step(1'b0);
    expectOut(0, 1'b0, "R4 saturate bottom");

    // R9: a strobe during busy is ignored
    selN = 1'b1;
    idle(1);
    selN = 1'b0;
    idle(1);
    dirUp = 1'b1;
    stepStrobe = 1'b0;
    idle(4);
    stepStrobe = 1'b1;
    expectOut(0, 1'b1, "R9 step ignored while busy");
    idle(15);
    expectOut(0, 1'b0, "R9 still unchanged after busy");
    step(1'b1);
    expectOut(1, 1'b0, "R9 steps resume after busy");

    // R8: reset reloads the committed 0
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(4);
    expectOut(0, 1'b0, "R8 R5 reload committed zero");

    // R1: power-on restores mid-scale in wiper and store
    porN = 1'b0;
    idle(2);
    porN = 1'b1;
    idle(4);
    expectOut(16, 1'b0, "R1 power-on wiper");
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(4);
    expectOut(16, 1'b0, "R1 power-on store");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule